// File: doc/BRIEF.md
# Synthesizer Status Pin Multiplexer

This block drives the single shared status pin of a two-loop frequency synthesizer. A four-bit mode code, built from a lock-enable bit and a probe bit for each loop, picks what the pin carries. It can carry a lock indication for either loop or for both together, a copy of either loop's reference or feedback divider pulse, a fast-lock switch control, or a held-low level. One code raises a global counter-reset command, and two codes are reserved.

Each loop has a lock monitor that watches its phase-detector up and down pulses. A comparison period ends on a reference divider tick. The period is clean when no up or down activity lasts longer than `MAX_W` clock cycles. After `LOCK_CNT` clean periods in a row the loop is marked locked, and one unclean period clears the mark. In a lock-detect mode the pin is high while the loop is locked and goes low for the duration of each phase-detector pulse, so a locked loop shows narrow low pulses.

The pin value, the output drive enable (1 = drive the pin, 0 = release it) and the counter-reset command are all registered. Each one follows its inputs with one clock of latency.

Top module: `status_pin_mux`

## Requirements
- R1: While `rst` is high, and at the first sample after it, `stat_pin`, `stat_oe` and `cnt_reset` are all 0.
- R2: Mode code `mode_sel` = 4'b0000 drives the pin low: `stat_pin`=0, `stat_oe`=1. The bit order of `mode_sel` is {loop-1 lock enable, loop-2 lock enable, loop-1 probe, loop-2 probe}.
- R3: With both probe bits 0, codes 4'b1000, 4'b0100 and 4'b1100 put the following on the pin, with `stat_oe`=1: loop-1 lock, loop-2 lock, and the AND of both. A loop's lock level is its lock flag gated low while its up or down pulse is active.
- R4: A loop's lock flag changes only on a cycle where its `ref_tick` is high. On that cycle it is set if this period and the `LOCK_CNT`-1 periods before it were all clean. It is cleared if any up or down run in this period lasted more than `MAX_W` cycles.
- R5: Codes x001 and x010 put on the pin the reference tick of loop 2 (`ref_tick[1]`) and of loop 1 (`ref_tick[0]`) respectively, with `stat_oe`=1. The loop-1 lock-enable bit has no effect in these codes.
- R6: Codes x101 and x110 put on the pin the feedback tick of loop 2 (`fb_tick[1]`) and of loop 1 (`fb_tick[0]`) respectively, with `stat_oe`=1.
- R7: Code 4'b0011 is fast-lock: `stat_pin`=0, and `stat_oe` equals `fastlock_hi`. The pin is pulled low only while the loop-1 high-current bit is set.
- R8: `cnt_reset` is 1 exactly when the code was 4'b1111, and the pin is then driven low.
- R9: Reserved codes 4'b0111 and 4'b1011 drive the pin low (`stat_pin`=0, `stat_oe`=1) and leave `cnt_reset` at 0.
- R10: All three outputs follow the sampled inputs and lock flags with exactly one clock of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 4 | {lock-en loop 1, lock-en loop 2, probe loop 1, probe loop 2} |
| fastlock_hi | input | 1 | Loop-1 charge-pump high-current bit |
| pd_up | input | 2 | Phase-detector up pulse; bit 0 = loop 1, bit 1 = loop 2 |
| pd_dn | input | 2 | Phase-detector down pulse, per loop |
| ref_tick | input | 2 | Reference divider output pulse, per loop |
| fb_tick | input | 2 | Feedback divider output pulse, per loop |
| stat_pin | output | 1 | Registered status pin value |
| stat_oe | output | 1 | Registered drive enable (0 = released) |
| cnt_reset | output | 1 | Registered global counter-reset command |

## Verification
A wrong lock flag or a wrong run counter inside a monitor shows on the pin only in a lock-detect code. It first appears one clock after the reference tick that should have set or cleared the flag. A bad run count can therefore stay hidden for a whole period, or for `LOCK_CNT` periods. A decode error shows on the next clock of the affected code. For this reason the stimulus holds each code for many periods and also switches codes at random. Pulse widths straddle `MAX_W`, so the lock flag toggles repeatedly.

// File: rtl/spm_pkg.sv
package spm_pkg;
  localparam int NUM_LOOPS = 2;

  typedef enum logic [3:0] {
    SRC_OFF,
    SRC_LK1,
    SRC_LK2,
    SRC_LKB,
    SRC_REF1,
    SRC_REF2,
    SRC_FB1,
    SRC_FB2,
    SRC_FAST,
    SRC_CRST,
    SRC_RSVD
  } src_e;
endpackage

// File: rtl/spm_lock_mon.sv
module spm_lock_mon #(
  parameter int MAX_W    = 3,
  parameter int LOCK_CNT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic up,
  input  logic dn,
  input  logic ref_tick,
  output logic locked,
  output logic lock_lvl
);
  localparam int RW = $clog2(MAX_W + 2);
  localparam int GW = $clog2(LOCK_CNT + 1);

  logic [RW-1:0] run_q;
  logic [GW-1:0] good_q;
  logic          bad_q;
  logic          lock_q;
  logic          active;
  logic          too_wide;

  assign active   = up | dn;
  // current run length is run_q+1; it is too long when above MAX_W
  assign too_wide = active && (run_q >= RW'(MAX_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      good_q <= '0;
      bad_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      if (!active)       run_q <= '0;
      else if (!too_wide) run_q <= run_q + 1'b1;

      if (ref_tick) begin
        bad_q <= 1'b0;
        if (bad_q || too_wide) begin
          good_q <= '0;
          lock_q <= 1'b0;
        end else begin
          if (good_q < GW'(LOCK_CNT)) good_q <= good_q + 1'b1;
          if (good_q >= GW'(LOCK_CNT - 1)) lock_q <= 1'b1;
        end
      end else if (too_wide) begin
        bad_q <= 1'b1;
      end
    end
  end

  assign locked   = lock_q;
  assign lock_lvl = lock_q & ~active;
endmodule

// File: rtl/spm_mode_decode.sv
module spm_mode_decode
  import spm_pkg::*;
(
  input  logic [3:0] mode_sel,
  output src_e       src
);
  logic lk1, lk2, pr1, pr2;
  assign {lk1, lk2, pr1, pr2} = mode_sel;

  always_comb begin
    unique case ({pr1, pr2})
      2'b00: begin
        unique case ({lk1, lk2})
          2'b00:   src = SRC_OFF;
          2'b01:   src = SRC_LK2;
          2'b10:   src = SRC_LK1;
          default: src = SRC_LKB;
        endcase
      end
      2'b01:   src = lk2 ? SRC_FB2 : SRC_REF2;
      2'b10:   src = lk2 ? SRC_FB1 : SRC_REF1;
      default: begin
        unique case ({lk1, lk2})
          2'b00:   src = SRC_FAST;
          2'b11:   src = SRC_CRST;
          default: src = SRC_RSVD;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/spm_pin_stage.sv
module spm_pin_stage
  import spm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  src_e                 src,
  input  logic [NUM_LOOPS-1:0] lock_lvl,
  input  logic [NUM_LOOPS-1:0] ref_tick,
  input  logic [NUM_LOOPS-1:0] fb_tick,
  input  logic                 fastlock_hi,
  output logic                 pin_q,
  output logic                 oe_q,
  output logic                 crst_q
);
  logic pin_d, oe_d, crst_d;

  always_comb begin
    pin_d  = 1'b0;
    oe_d   = 1'b1;
    crst_d = 1'b0;
    unique case (src)
      SRC_LK1:  pin_d = lock_lvl[0];
      SRC_LK2:  pin_d = lock_lvl[1];
      SRC_LKB:  pin_d = &lock_lvl;
      SRC_REF1: pin_d = ref_tick[0];
      SRC_REF2: pin_d = ref_tick[1];
      SRC_FB1:  pin_d = fb_tick[0];
      SRC_FB2:  pin_d = fb_tick[1];
      SRC_FAST: oe_d  = fastlock_hi;
      SRC_CRST: crst_d = 1'b1;
      default:  pin_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q  <= 1'b0;
      oe_q   <= 1'b0;
      crst_q <= 1'b0;
    end else begin
      pin_q  <= pin_d;
      oe_q   <= oe_d;
      crst_q <= crst_d;
    end
  end
endmodule

// File: rtl/status_pin_mux.sv
module status_pin_mux
  import spm_pkg::*;
#(
  parameter int MAX_W    = 3,
  parameter int LOCK_CNT = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [3:0]           mode_sel,
  input  logic                 fastlock_hi,
  input  logic [NUM_LOOPS-1:0] pd_up,
  input  logic [NUM_LOOPS-1:0] pd_dn,
  input  logic [NUM_LOOPS-1:0] ref_tick,
  input  logic [NUM_LOOPS-1:0] fb_tick,
  output logic                 stat_pin,
  output logic                 stat_oe,
  output logic                 cnt_reset
);
  logic [NUM_LOOPS-1:0] lock_q;
  logic [NUM_LOOPS-1:0] lock_lvl;
  src_e                 src;

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
    spm_lock_mon #(.MAX_W(MAX_W), .LOCK_CNT(LOCK_CNT)) mon_i (
      .clk      (clk),
      .rst      (rst),
      .up       (pd_up[g]),
      .dn       (pd_dn[g]),
      .ref_tick (ref_tick[g]),
      .locked   (lock_q[g]),
      .lock_lvl (lock_lvl[g])
    );
  end

  spm_mode_decode dec_i (
    .mode_sel (mode_sel),
    .src      (src)
  );

  spm_pin_stage stage_i (
    .clk         (clk),
    .rst         (rst),
    .src         (src),
    .lock_lvl    (lock_lvl),
    .ref_tick    (ref_tick),
    .fb_tick     (fb_tick),
    .fastlock_hi (fastlock_hi),
    .pin_q       (stat_pin),
    .oe_q        (stat_oe),
    .crst_q      (cnt_reset)
  );
endmodule

// File: rtl/spm_checker.sv
module spm_checker (
  input logic       clk,
  input logic       rst,
  input logic [3:0] mode_sel,
  input logic       fastlock_hi,
  input logic [1:0] ref_tick,
  input logic [1:0] lock_q,
  input logic       stat_pin,
  input logic       stat_oe,
  input logic       cnt_reset
);
  // R1
  after_reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (!stat_pin && !stat_oe && !cnt_reset));

  // R2
  off_code_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_sel) == 4'b0000) |-> (!stat_pin && stat_oe));

  // R3
  lock1_pin_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_sel) == 4'b1000 && stat_pin) |-> $past(lock_q[0]));

  // R4
  lock1_rise_on_ref_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_q[0]) |-> $past(ref_tick[0]));

  // R4
  lock2_rise_on_ref_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_q[1]) |-> $past(ref_tick[1]));

  // R7
  fastlock_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_sel) == 4'b0011) |-> (!stat_pin && stat_oe == $past(fastlock_hi)));

  // R8
  crst_only_code_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_reset |-> ($past(mode_sel) == 4'b1111 && !stat_pin));

  // R9
  reserved_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(mode_sel) == 4'b0111 || $past(mode_sel) == 4'b1011))
      |-> (!stat_pin && stat_oe && !cnt_reset));
endmodule

bind status_pin_mux spm_checker chk_i (
  .clk         (clk),
  .rst         (rst),
  .mode_sel    (mode_sel),
  .fastlock_hi (fastlock_hi),
  .ref_tick    (ref_tick),
  .lock_q      (lock_q),
  .stat_pin    (stat_pin),
  .stat_oe     (stat_oe),
  .cnt_reset   (cnt_reset)
);

// File: tb/status_pin_mux_tb_top.sv
module status_pin_mux_tb_top;
  localparam int MAX_W    = 3;
  localparam int LOCK_CNT = 4;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] mode_sel;
  logic       fastlock_hi;
  logic [1:0] pd_up, pd_dn, ref_tick, fb_tick;
  logic       stat_pin, stat_oe, cnt_reset;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  status_pin_mux #(.MAX_W(MAX_W), .LOCK_CNT(LOCK_CNT)) dut_i (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .fastlock_hi(fastlock_hi),
    .pd_up(pd_up), .pd_dn(pd_dn), .ref_tick(ref_tick), .fb_tick(fb_tick),
    .stat_pin(stat_pin), .stat_oe(stat_oe), .cnt_reset(cnt_reset)
  );

  // reference model state
  int run_m[2];
  bit bad_m[2];
  int good_m[2];
  bit lk_m[2];
  int pulse_left[2];
  bit pulse_is_up[2];
  bit exp_pin, exp_oe, exp_crst;
  string exp_tag;

  function automatic string tag_of(logic [3:0] m);
    case (m)
      4'b0000: return "R2";
      4'b1000, 4'b0100, 4'b1100: return "R3 R4";
      4'b0001, 4'b1001, 4'b0010, 4'b1010: return "R5";
      4'b0101, 4'b1101, 4'b0110, 4'b1110: return "R6";
      4'b0011: return "R7";
      4'b1111: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b (mode %b)", req, what, act, exp, mode_sel);
    end
  endtask

  // compute expected registered outputs from current inputs and model, then advance model
  task automatic model_step();
    bit lvl[2];
    for (int i = 0; i < 2; i++) lvl[i] = lk_m[i] && !(pd_up[i] || pd_dn[i]);
    exp_tag = tag_of(mode_sel);
    if (rst) begin
      exp_pin = 0; exp_oe = 0; exp_crst = 0; exp_tag = "R1";
    end else begin
      exp_pin = 0; exp_oe = 1; exp_crst = 0;
      case (mode_sel)
        4'b1000: exp_pin = lvl[0];
        4'b0100: exp_pin = lvl[1];
        4'b1100: exp_pin = lvl[0] && lvl[1];
        4'b0001, 4'b1001: exp_pin = ref_tick[1];
        4'b0010, 4'b1010: exp_pin = ref_tick[0];
        4'b0101, 4'b1101: exp_pin = fb_tick[1];
        4'b0110, 4'b1110: exp_pin = fb_tick[0];
        4'b0011: exp_oe = fastlock_hi;
        4'b1111: exp_crst = 1;
        default: exp_pin = 0;
      endcase
    end
    for (int i = 0; i < 2; i++) begin
      bit act, wide;
      if (rst) begin
        run_m[i] = 0; bad_m[i] = 0; good_m[i] = 0; lk_m[i] = 0;
      end else begin
        act = pd_up[i] || pd_dn[i];
        run_m[i] = act ? run_m[i] + 1 : 0;
        wide = act && (run_m[i] > MAX_W);
        if (ref_tick[i]) begin
          if (bad_m[i] || wide) begin
            good_m[i] = 0; lk_m[i] = 0;
          end else begin
            good_m[i]++;
            if (good_m[i] >= LOCK_CNT) lk_m[i] = 1;
          end
          bad_m[i] = 0;
        end else if (wide) begin
          bad_m[i] = 1;
        end
      end
    end
  endtask

  // one cycle: inputs already driven; check outputs of last edge, predict, advance
  task automatic cycle(bit wide_ok);
    @(negedge clk);
    chk(exp_tag, "stat_pin R10", stat_pin, exp_pin);
    chk(exp_tag, "stat_oe", stat_oe, exp_oe);
    chk(exp_crst ? "R8" : exp_tag, "cnt_reset", cnt_reset, exp_crst);
    model_step();
    @(posedge clk); #1;
    // next random pulse inputs
    for (int i = 0; i < 2; i++) begin
      ref_tick[i] = ($urandom_range(0, 6) == 0);
      fb_tick[i]  = ($urandom_range(0, 4) == 0);
      if (pulse_left[i] == 0 && $urandom_range(0, 4) == 0) begin
        pulse_left[i]  = (wide_ok && $urandom_range(0, 5) == 0) ? $urandom_range(MAX_W + 1, MAX_W + 3)
                                                                 : $urandom_range(1, MAX_W);
        pulse_is_up[i] = $urandom_range(0, 1);
      end
      pd_up[i] = (pulse_left[i] > 0) && pulse_is_up[i];
      pd_dn[i] = (pulse_left[i] > 0) && !pulse_is_up[i];
      if (pulse_left[i] > 0) pulse_left[i]--;
    end
    if ($urandom_range(0, 3) == 0) fastlock_hi = ~fastlock_hi;
  endtask

  initial begin
    int unsigned s;
    s = $urandom(32'd4242);
    rst = 1; mode_sel = 4'b0000; fastlock_hi = 0;
    pd_up = 0; pd_dn = 0; ref_tick = 0; fb_tick = 0;
    for (int i = 0; i < 2; i++) begin
      run_m[i] = 0; bad_m[i] = 0; good_m[i] = 0; lk_m[i] = 0; pulse_left[i] = 0;
    end
    exp_pin = 0; exp_oe = 0; exp_crst = 0; exp_tag = "R1";
    @(posedge clk); #1;
    // R1: reset state, drive busy inputs during reset
    mode_sel = 4'b1111; pd_up = 2'b11; ref_tick = 2'b11;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (k > 0) begin
        chk("R1", "stat_pin", stat_pin, 1'b0);
        chk("R1", "stat_oe", stat_oe, 1'b0);
        chk("R1", "cnt_reset", cnt_reset, 1'b0);
      end
      model_step();
      @(posedge clk); #1;
    end
    rst = 0; pd_up = 0; ref_tick = 0; mode_sel = 4'b1100;
    // R3 R4: acquire lock on narrow pulses, then allow wide ones
    for (int k = 0; k < 300; k++) cycle(1'b0);
    for (int k = 0; k < 300; k++) cycle(1'b1);
    // every code held for a stretch, including reserved (R9) and reset (R8)
    for (int m = 0; m < 16; m++) begin
      mode_sel = 4'(m);
      for (int k = 0; k < 120; k++) cycle(k < 60 ? 1'b0 : 1'b1);
    end
    // R9 reserved codes directed again, R7 fast-lock both bit values
    mode_sel = 4'b0111; cycle(1'b1); mode_sel = 4'b1011; cycle(1'b1);
    mode_sel = 4'b0011;
    for (int k = 0; k < 20; k++) cycle(1'b1);
    // random code switching
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 5) == 0) mode_sel = 4'($urandom_range(0, 15));
      cycle($urandom_range(0, 1) == 1);
    end
    // reset in the middle of operation: R1
    rst = 1; cycle(1'b0); rst = 0; mode_sel = 4'b1000;
    for (int k = 0; k < 200; k++) cycle(1'b0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule